// File: doc/BRIEF.md
# Masked Grouped Pattern Matcher

This block searches one logic cone of six detector planes for a track, using a reduced set of comparators. Patterns that share sign, pT code and quality definition are merged offline into one group, and each group is stored as a strip mask per plane: the union of its member patterns. When a hit vector arrives, every plane in which no strip fired is filled, so that all its strips count as fired. Each group is then tested with a single AND across the six planes: a plane passes when its filled or genuine hits overlap the group mask in that plane.

The quality of a matching group is the number of planes that were genuinely hit and overlap its mask, minus three. A group with fewer than three genuine planes is rejected. The winner is reported as a registered pT code, sign and 2-bit quality with a valid flag. Group masks, pT codes and signs are loaded one group at a time through a configuration write port.

A plane that holds only a stray hit outside the mask is not empty. It is therefore not filled, and the group fails. The block keeps this known weakness on purpose.

Top module: `mgpm_matcher`

## Requirements
- R1: Reset (rst_n low at a clock edge) clears all outputs to zero and clears every group mask, so that no group can match until it is written again.
- R2: A write with cfg_we high stores cfg_mask, cfg_pt and cfg_sign into group cfg_addr at the clock edge. A hit vector sampled at that same edge is still evaluated with the old contents.
- R3: Bits [p*NSTRIP +: NSTRIP] of hit_strips and cfg_mask belong to plane p. A plane with no hit bit set is filled (all strips treated as fired). A group whose mask is zero in any plane never matches.
- R4: A group matches when every plane is either empty or has at least one hit strip that is also set in the group mask for that plane.
- R5: A plane with hits that all fall outside the group mask is not filled, so the group fails even when every other plane matches.
- R6: Quality is the number of genuinely hit planes overlapping the mask, minus 3, so 6 planes give 3 and 3 planes give 0. Fewer than 3 such planes reject the group. All matching groups share one quality, namely the count of non-empty planes minus 3.
- R7: Among matching groups the highest pT code wins. On equal pT code the lowest group index wins, and its sign is reported.
- R8: The result for a hit vector sampled with hit_valid high appears on the outputs one cycle later. After a cycle with hit_valid low, or when no group matches, res_valid is 0 and res_pt, res_sign and res_quality are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Group write strobe |
| cfg_addr | input | $clog2(NGROUP) | Group index to write |
| cfg_mask | input | NPLANE*NSTRIP | Strip mask, plane p at [p*NSTRIP +: NSTRIP] |
| cfg_pt | input | PT_W | pT code of the group |
| cfg_sign | input | 1 | Sign of the group |
| hit_valid | input | 1 | Hit vector present this cycle |
| hit_strips | input | NPLANE*NSTRIP | Fired strips, plane p at [p*NSTRIP +: NSTRIP] |
| res_valid | output | 1 | A group matched |
| res_pt | output | PT_W | pT code of the winning group |
| res_sign | output | 1 | Sign of the winning group |
| res_quality | output | 2 | Quality of the winning group |

## Verification
Every result is due exactly one clock edge after the hit vector is sampled, and a configuration write is due at the edge that samples it. The bench drives inputs on the falling edge and reads outputs on the next falling edge, which is half a cycle after the single register stage has loaded. One directed test puts a write and a hit vector on the same edge, checks that the old mask was used, and then checks the new mask on the following vector. Another drops hit_valid and checks that the outputs return to zero one cycle later.

// File: rtl/mgpm_pkg.sv
// Package: constants shared by the grouped pattern matcher.
// Assumes a cone of at most six planes, so quality fits two bits.
package mgpm_pkg;
    localparam int QUAL_W     = 2;  // quality field width
    localparam int MIN_PLANES = 3;  // fewest genuine planes for a match
endpackage

// File: rtl/mgpm_cfg_store.sv
// Group configuration store: one mask, pT code and sign per group.
// Assumes NGROUP is a power of two. Writes land at the clock edge;
// reset clears every entry so that no group can match.
module mgpm_cfg_store #(
    parameter int NGROUP = 8,
    parameter int NBITS  = 48,
    parameter int PT_W   = 5,
    localparam int AW    = $clog2(NGROUP)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [AW-1:0]                 cfg_addr,
    input  logic [NBITS-1:0]              cfg_mask,
    input  logic [PT_W-1:0]               cfg_pt,
    input  logic                          cfg_sign,
    output logic [NGROUP-1:0][NBITS-1:0]  grp_mask,
    output logic [NGROUP-1:0][PT_W-1:0]   grp_pt,
    output logic [NGROUP-1:0]             grp_sign
);
    for (genvar g = 0; g < NGROUP; g++) begin : g_entry
        // Holds one group entry; cleared by reset, loaded on an addressed write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                grp_mask[g] <= '0;
                grp_pt[g]   <= '0;
                grp_sign[g] <= 1'b0;
            end else if (cfg_we && cfg_addr == AW'(g)) begin
                grp_mask[g] <= cfg_mask;
                grp_pt[g]   <= cfg_pt;
                grp_sign[g] <= cfg_sign;
            end
        end

        AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_addr == AW'(g)) |=> (grp_mask[g] == $past(cfg_mask) && grp_pt[g] == $past(cfg_pt))) else $error("cfg write lost"); // R2
    end
endmodule

// File: rtl/mgpm_group_eval.sv
// Evaluates one group against the hit vector: fills empty planes,
// requires every plane to overlap the mask, and derives quality from
// the genuinely hit planes. Purely combinational.
module mgpm_group_eval
    import mgpm_pkg::*;
#(
    parameter int NPLANE = 6,
    parameter int NSTRIP = 8,
    localparam int NBITS = NPLANE * NSTRIP,
    localparam int CW    = $clog2(NPLANE + 1)
) (
    input  logic [NBITS-1:0]  hits,
    input  logic [NBITS-1:0]  mask,
    output logic              grp_ok,
    output logic [QUAL_W-1:0] grp_qual
);
    logic [NPLANE-1:0] empty_pl;
    logic [NPLANE-1:0] genuine_pl;
    logic [NPLANE-1:0] pass_pl;
    logic [NPLANE-1:0] zmask_pl;
    logic [CW-1:0]     genuine_cnt;

    for (genvar p = 0; p < NPLANE; p++) begin : g_plane
        logic [NSTRIP-1:0] h, m, f;
        assign h             = hits[p*NSTRIP +: NSTRIP];
        assign m             = mask[p*NSTRIP +: NSTRIP];
        assign empty_pl[p]   = ~|h;
        assign f             = empty_pl[p] ? '1 : h;
        assign genuine_pl[p] = |(h & m);
        assign pass_pl[p]    = |(f & m);
        assign zmask_pl[p]   = ~|m;
    end

    // Counts planes with a real hit inside the group mask.
    always_comb begin
        genuine_cnt = '0;
        for (int i = 0; i < NPLANE; i++)
            genuine_cnt = genuine_cnt + CW'(genuine_pl[i]);
    end

    // Single AND across planes plus the minimum-plane rule; quality offset by three.
    always_comb begin
        grp_ok   = (&pass_pl) && (genuine_cnt >= CW'(MIN_PLANES));
        grp_qual = grp_ok ? QUAL_W'(genuine_cnt - CW'(MIN_PLANES)) : '0;
    end

    // Checks a matching group against the non-empty plane count.
    always_comb begin
        if (grp_ok)
            AST_QUAL_FROM_FILLED: assert (grp_qual == QUAL_W'($countones(~empty_pl) - MIN_PLANES)) else $error("quality mismatch"); // R6
        if (|zmask_pl)
            AST_ZERO_MASK_REJECT: assert (!grp_ok) else $error("zero-mask plane matched"); // R3
    end
endmodule

// File: rtl/mgpm_best_select.sv
// Picks the winning group: highest pT code, lowest index on a tie.
// Assumes all matching groups share one quality (it depends only on
// the non-empty plane count), so quality is carried and not compared.
module mgpm_best_select
    import mgpm_pkg::*;
#(
    parameter int NGROUP = 8,
    parameter int PT_W   = 5
) (
    input  logic [NGROUP-1:0]              grp_ok,
    input  logic [NGROUP-1:0][PT_W-1:0]    grp_pt,
    input  logic [NGROUP-1:0]              grp_sign,
    input  logic [NGROUP-1:0][QUAL_W-1:0]  grp_qual,
    output logic                           win_valid,
    output logic [PT_W-1:0]                win_pt,
    output logic                           win_sign,
    output logic [QUAL_W-1:0]              win_qual
);
    // Linear scan; strict comparison keeps the lowest index on equal pT.
    always_comb begin
        win_valid = 1'b0;
        win_pt    = '0;
        win_sign  = 1'b0;
        win_qual  = '0;
        for (int g = 0; g < NGROUP; g++) begin
            if (grp_ok[g] && (!win_valid || grp_pt[g] > win_pt)) begin
                win_valid = 1'b1;
                win_pt    = grp_pt[g];
                win_sign  = grp_sign[g];
                win_qual  = grp_qual[g];
            end
        end
    end

    // Every matching group is bounded by the winner and shares its quality.
    always_comb begin
        for (int g = 0; g < NGROUP; g++) begin
            if (grp_ok[g]) begin
                AST_BEST_PT: assert (win_valid && grp_pt[g] <= win_pt) else $error("winner not best"); // R7
                AST_SAME_QUALITY: assert (grp_qual[g] == win_qual) else $error("quality differs"); // R6
            end
        end
    end
endmodule

// File: rtl/mgpm_matcher.sv
// Top of the masked grouped pattern matcher. Stores group masks, evaluates
// all groups in parallel on a hit vector and registers the best result.
// Assumes NGROUP is a power of two and NPLANE is at most six.
module mgpm_matcher
    import mgpm_pkg::*;
#(
    parameter int NPLANE = 6,
    parameter int NSTRIP = 8,
    parameter int NGROUP = 8,
    parameter int PT_W   = 5,
    localparam int NBITS = NPLANE * NSTRIP,
    localparam int AW    = $clog2(NGROUP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [NBITS-1:0]  cfg_mask,
    input  logic [PT_W-1:0]   cfg_pt,
    input  logic              cfg_sign,
    input  logic              hit_valid,
    input  logic [NBITS-1:0]  hit_strips,
    output logic              res_valid,
    output logic [PT_W-1:0]   res_pt,
    output logic              res_sign,
    output logic [QUAL_W-1:0] res_quality
);
    logic [NGROUP-1:0][NBITS-1:0]  grp_mask;
    logic [NGROUP-1:0][PT_W-1:0]   grp_pt;
    logic [NGROUP-1:0]             grp_sign;
    logic [NGROUP-1:0]             grp_ok;
    logic [NGROUP-1:0][QUAL_W-1:0] grp_qual;
    logic                          win_valid;
    logic [PT_W-1:0]               win_pt;
    logic                          win_sign;
    logic [QUAL_W-1:0]             win_qual;

    mgpm_cfg_store #(.NGROUP(NGROUP), .NBITS(NBITS), .PT_W(PT_W)) u_store (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_mask(cfg_mask), .cfg_pt(cfg_pt), .cfg_sign(cfg_sign),
        .grp_mask(grp_mask), .grp_pt(grp_pt), .grp_sign(grp_sign)
    );

    for (genvar g = 0; g < NGROUP; g++) begin : g_eval
        mgpm_group_eval #(.NPLANE(NPLANE), .NSTRIP(NSTRIP)) u_eval (
            .hits(hit_strips), .mask(grp_mask[g]),
            .grp_ok(grp_ok[g]), .grp_qual(grp_qual[g])
        );
    end

    mgpm_best_select #(.NGROUP(NGROUP), .PT_W(PT_W)) u_sel (
        .grp_ok(grp_ok), .grp_pt(grp_pt), .grp_sign(grp_sign), .grp_qual(grp_qual),
        .win_valid(win_valid), .win_pt(win_pt), .win_sign(win_sign), .win_qual(win_qual)
    );

    // Result register: loads the winner for a valid vector, else returns to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !(hit_valid && win_valid)) begin
            res_valid   <= 1'b0;
            res_pt      <= '0;
            res_sign    <= 1'b0;
            res_quality <= '0;
        end else begin
            res_valid   <= 1'b1;
            res_pt      <= win_pt;
            res_sign    <= win_sign;
            res_quality <= win_qual;
        end
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (res_pt == '0 && !res_sign && res_quality == '0)) else $error("idle fields"); // R8
    AST_VALID_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_valid |=> !res_valid) else $error("valid without strobe"); // R8
endmodule

// File: tb/mgpm_matcher_tb.sv
// Bench for mgpm_matcher: a vector table walked by one loop, then
// directed tests for reset, write timing, idle strobe and zero-mask planes.
module mgpm_matcher_tb;
    localparam int NV = 11;
    // Expected result packed as {valid, sign, quality[1:0], pt[4:0]}.
    localparam logic [47:0] T_HITS [NV] = '{
        48'h010101010101,  // R4: all planes on strip 0 -> G0 q3
        48'h000001010101,  // R3: planes 4,5 empty -> G0 q1
        48'h000000010101,  // R6: three planes -> G0 q0
        48'h000000000101,  // R6: two planes -> reject
        48'h800101010101,  // R5: stray hit in plane 5 -> reject
        48'h070707070707,  // R7: G0 and G1 match, pT 20 wins
        48'h101010101010,  // R7: G2,G3,G4 match, G3 (pT 7, lowest index)
        48'h202020202020,  // R7: only G4
        48'h000000000000,  // R6: nothing hit -> reject
        48'h040404020202,  // R4: different strips within G1 mask
        48'h201010101010   // R5: plane 5 outside G2/G3 mask -> G4
    };
    localparam logic [8:0] T_EXP [NV] = '{
        {1'b1, 1'b0, 2'd3, 5'd10},
        {1'b1, 1'b0, 2'd1, 5'd10},
        {1'b1, 1'b0, 2'd0, 5'd10},
        9'd0,
        9'd0,
        {1'b1, 1'b1, 2'd3, 5'd20},
        {1'b1, 1'b0, 2'd3, 5'd7},
        {1'b1, 1'b1, 2'd3, 5'd7},
        9'd0,
        {1'b1, 1'b1, 2'd3, 5'd20},
        {1'b1, 1'b1, 2'd3, 5'd7}
    };
    localparam string T_REQ [NV] = '{"R4", "R3", "R6", "R6", "R5", "R7", "R7", "R7", "R6", "R4", "R5"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [47:0] cfg_mask = '0;
    logic [4:0]  cfg_pt = '0;
    logic        cfg_sign = 1'b0;
    logic        hit_valid = 1'b0;
    logic [47:0] hit_strips = '0;
    logic        res_valid;
    logic [4:0]  res_pt;
    logic        res_sign;
    logic [1:0]  res_quality;
    int          n_checks = 0;
    int          n_fail = 0;

    always #10 clk = ~clk;  // 50 MHz

    mgpm_matcher u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_mask(cfg_mask), .cfg_pt(cfg_pt), .cfg_sign(cfg_sign),
        .hit_valid(hit_valid), .hit_strips(hit_strips),
        .res_valid(res_valid), .res_pt(res_pt), .res_sign(res_sign),
        .res_quality(res_quality)
    );

    task automatic check(input string req, input logic [8:0] exp);
        logic [8:0] act;
        act = {res_valid, res_sign, res_quality, res_pt};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got v=%0b s=%0b q=%0d pt=%0d, expected v=%0b s=%0b q=%0d pt=%0d",
                     req, act[8], act[7], act[6:5], act[4:0], exp[8], exp[7], exp[6:5], exp[4:0]);
        end
    endtask

    task automatic write_grp(input int g, input logic [7:0] plane_mask, input int pt, input logic sgn);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_addr = 3'(g);
        cfg_mask = {6{plane_mask}};
        cfg_pt   = 5'(pt);
        cfg_sign = sgn;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Drives a vector on a falling edge; its result is read on the next falling edge.
    task automatic run_vec(input logic [47:0] h, input string req, input logic [8:0] exp);
        @(negedge clk);
        hit_valid  = 1'b1;
        hit_strips = h;
        @(negedge clk);
        hit_valid = 1'b0;
        check(req, exp);
    endtask

    task automatic load_groups();
        write_grp(0, 8'h01, 10, 1'b0);
        write_grp(1, 8'h06, 20, 1'b1);
        write_grp(2, 8'h10, 5, 1'b1);
        write_grp(3, 8'h10, 7, 1'b0);
        write_grp(4, 8'h30, 7, 1'b1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 9'd0);                        // R1: outputs zero after reset

        load_groups();
        for (int i = 0; i < NV; i++) run_vec(T_HITS[i], T_REQ[i], T_EXP[i]);

        // R8: outputs return to zero one cycle after hit_valid drops
        run_vec(48'h010101010101, "R8", {1'b1, 1'b0, 2'd3, 5'd10});
        @(negedge clk);
        check("R8", 9'd0);

        // R2: write and vector on the same edge use the old pT, the next vector the new one
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'd0; cfg_mask = {6{8'h01}}; cfg_pt = 5'd25; cfg_sign = 1'b1;
        hit_valid = 1'b1; hit_strips = 48'h010101010101;
        @(negedge clk);
        cfg_we = 1'b0;
        check("R2", {1'b1, 1'b0, 2'd3, 5'd10});
        @(negedge clk);
        hit_valid = 1'b0;
        check("R2", {1'b1, 1'b1, 2'd3, 5'd25});

        // R3: G5 has plane 5 mask zero and pT 31; it must lose to G0 (pT 25, q2)
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'd5; cfg_mask = {8'h00, {5{8'hFF}}}; cfg_pt = 5'd31; cfg_sign = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0;
        run_vec(48'h000101010101, "R3", {1'b1, 1'b1, 2'd2, 5'd25});

        // R1: reset clears masks, so a full-hit vector no longer matches
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", 9'd0);
        run_vec(48'h010101010101, "R1", 9'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule